// File: doc/BRIEF.md
# Lockable Flash Timing Clock Prescaler

This block holds an 8-bit divider control register and a prescaler that turns the bus clock into a roughly 1 MHz timing tick. The flash program and erase sequencer uses that tick to pace its timed events. Software sets the 6-bit divider value through a simple write port and can read the whole register back at any time.

The register guards itself in three ways. A read-only flag shows whether any write has been accepted since reset. A lock bit can be set once and is cleared only by reset; while it is set, the divider value is frozen. Writes are refused while a flash command is running, which the command-complete input shows by being low. The one exception is the flash reset sequence: while it is active, writes are accepted even though the command-complete input is low.

The tick output is a one-cycle pulse. Whenever the divider value changes, the prescaler restarts from zero, so the first tick after a change comes a full period after the write.

Top module: `flash_tick_prescaler`

## Requirements
- R1: While `rst` is high and in the cycle after, `rd_data` reads 0x00 and `tick` is low. This holds for the written-flag, the lock bit and the divider value.
- R2: `rd_data` always shows the register. Bit 7 is the written-flag, bit 6 is the lock bit and bits 5..0 are the divider value.
- R3: The written-flag reads 0 until a write is accepted after reset, and 1 from then on. Bit 7 of `wr_data` has no effect on it.
- R4: Once the lock bit is 1, writing 0 to bit 6 does not clear it. Only `rst` clears it.
- R5: While the lock bit is 1, accepted writes leave the divider value unchanged. A single write may load a divider value and set the lock bit together.
- R6: A write with `cmd_done` low and `rst_seq_active` low is ignored completely. The written-flag, the lock bit and the divider value all keep their values.
- R7: A write with `cmd_done` low and `rst_seq_active` high is accepted.
- R8: With divider value D held constant, `tick` is high for exactly one cycle in every D+1 cycles. When D is 0, `tick` stays high.
- R9: When an accepted write changes the divider value to D, the prescaler restarts. `tick` next rises in the (D+1)-th cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data |
| cmd_done | input | 1 | High when no flash command is running |
| rst_seq_active | input | 1 | High during the flash reset sequence |
| rd_data | output | 8 | Register read value |
| tick | output | 1 | Timing tick pulse |

## Verification
The bench loads divider values 4, 0, 63, 10 and 3. For each value it finds the cycle of the first tick and counts the ticks in three periods. This separates a wrong period, a missing restart, and a pulse that lasts too long. One write cuts a count short by changing the divider while the count is running. Writes are also tried under each combination of the busy and reset-sequence inputs, and each time the register readback shows whether the write was accepted. Further writes check the lock: one sets it and loads a divider in the same write, later ones try to clear it or to change the divider, and a reset then clears it.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
  // Default divider field width; the register adds the lock and written bits.
  localparam int DEF_DIV_W = 6;
endpackage

// File: rtl/fclk_wr_gate.sv
module fclk_wr_gate (
  input  logic wr_en,
  input  logic cmd_done,
  input  logic rst_seq_active,
  output logic wr_ok
);
  // A write may land when no command is busy, or during the reset sequence.
  assign wr_ok = wr_en & (cmd_done | rst_seq_active);
endmodule

// File: rtl/fclk_ctrl_reg.sv
module fclk_ctrl_reg #(
  parameter int DIV_W = fclk_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  logic [DIV_W:0]   wr_bits,
  output logic             loaded_q,
  output logic             lock_q,
  output logic [DIV_W-1:0] div_q,
  output logic             restart
);
  localparam int LOCK_POS = DIV_W;

  logic [DIV_W-1:0] new_div;
  assign new_div = wr_bits[DIV_W-1:0];

  // Restart the prescaler only when the divider value really changes.
  assign restart = wr_ok && !lock_q && (new_div != div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q <= 1'b0;
      lock_q   <= 1'b0;
      div_q    <= '0;
    end else if (wr_ok) begin
      loaded_q <= 1'b1;
      lock_q   <= lock_q | wr_bits[LOCK_POS];
      if (!lock_q) div_q <= new_div;
    end
  end

  assert_loaded_set_R3: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> loaded_q);
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  assert_div_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(div_q));
  assert_blocked_no_change_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable({loaded_q, lock_q, div_q}));
endmodule

// File: rtl/fclk_tick_gen.sv
module fclk_tick_gen #(
  parameter int DIV_W = fclk_pkg::DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == div) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div);
  assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
    (tick_q && div != '0) |=> !tick_q);
  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!tick_q && cnt_q == '0));
endmodule

// File: rtl/flash_tick_prescaler.sv
module flash_tick_prescaler #(
  parameter int DIV_W = fclk_pkg::DEF_DIV_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DIV_W+1:0]   wr_data,
  input  logic               cmd_done,
  input  logic               rst_seq_active,
  output logic [DIV_W+1:0]   rd_data,
  output logic               tick
);
  localparam int REG_W = DIV_W + 2;

  logic             wr_ok;
  logic             loaded_q;
  logic             lock_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;
  logic             unused_wbit;

  // The written-flag is read-only; its write data bit is dropped.
  assign unused_wbit = wr_data[REG_W-1];

  fclk_wr_gate i_gate (
    .wr_en          (wr_en),
    .cmd_done       (cmd_done),
    .rst_seq_active (rst_seq_active),
    .wr_ok          (wr_ok)
  );

  fclk_ctrl_reg #(.DIV_W(DIV_W)) i_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .wr_bits  (wr_data[DIV_W:0]),
    .loaded_q (loaded_q),
    .lock_q   (lock_q),
    .div_q    (div_q),
    .restart  (restart)
  );

  fclk_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk     (clk),
    .rst     (rst),
    .div     (div_q),
    .restart (restart),
    .tick    (tick)
  );

  assign rd_data = {loaded_q, lock_q, div_q};

  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cmd_done && !rst_seq_active) |=> $stable(rd_data));
  assert_reset_seq_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rst_seq_active) |=> rd_data[REG_W-1]);
endmodule

// File: tb/test_flash_tick_prescaler.sv
module test_flash_tick_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_done = 1'b1;
  logic       rst_seq_active = 1'b0;
  logic [7:0] rd_data;
  logic       tick;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_tick_prescaler i_flash_tick_prescaler (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_done(cmd_done), .rst_seq_active(rst_seq_active),
    .rd_data(rd_data), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(tick == 1'b0, "R1 tick", tick, 0);
    rst = 1'b0;
  endtask

  // Called right after do_write: first tick at sample D+1, three in 3(D+1).
  task automatic measure(input int d, input string req);
    int first = -1;
    int seen = 0;
    for (int j = 1; j <= 3 * (d + 1); j++) begin
      @(negedge clk);
      if (tick) begin
        seen++;
        if (first < 0) first = j;
      end
    end
    check(first == d + 1, {req, " first tick"}, first, d + 1);
    check(seen == 3, {req, " tick count"}, seen, 3);
  endtask

  task automatic t_reset();
    do_reset();
  endtask

  task automatic t_busy_write();
    cmd_done = 1'b0; rst_seq_active = 1'b0;
    do_write(8'h45);
    check(rd_data == 8'h00, "R6 busy write ignored", rd_data, 8'h00);
    check(rd_data[7] == 1'b0, "R3 flag stays clear", rd_data[7], 0);
  endtask

  task automatic t_reset_seq_write();
    cmd_done = 1'b0; rst_seq_active = 1'b1;
    do_write(8'h05);
    check(rd_data == 8'h85, "R7 reset-seq write accepted", rd_data, 8'h85);
    check(rd_data[7] == 1'b1, "R3 flag set by write", rd_data[7], 1);
    cmd_done = 1'b1; rst_seq_active = 1'b0;
  endtask

  task automatic t_periods();
    do_write(8'h04);
    check(rd_data == 8'h84, "R2 layout div=4", rd_data, 8'h84);
    measure(4, "R8 R9 div=4");
    do_write(8'h00);
    measure(0, "R8 div=0");
    do_write(8'h3F);
    check(rd_data == 8'hBF, "R2 layout div=63", rd_data, 8'hBF);
    measure(63, "R8 div=63");
    do_write(8'h0A);
    repeat (5) @(negedge clk);
    do_write(8'h83);
    check(rd_data == 8'h83, "R3 bit7 data ignored", rd_data, 8'h83);
    measure(3, "R9 restart mid-count");
  endtask

  task automatic t_lock();
    do_write(8'h47);
    check(rd_data == 8'hC7, "R5 lock and load together", rd_data, 8'hC7);
    measure(7, "R9 div=7");
    do_write(8'h02);
    check(rd_data[6] == 1'b1, "R4 lock not cleared", rd_data[6], 1);
    check(rd_data[5:0] == 6'd7, "R5 div frozen", rd_data[5:0], 7);
    do_reset();
    do_write(8'h02);
    check(rd_data == 8'h82, "R4 reset clears lock", rd_data, 8'h82);
  endtask

  initial begin
    t_reset();
    t_busy_write();
    t_reset_seq_write();
    t_periods();
    t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule